// File: doc/BRIEF.md
# Integer Carry, Overflow and Record Flag Unit

This unit sits beside a 32-bit integer adder and turns each add or subtract result into status flags. It owns a fixed-point status register that carries a carry flag, an overflow flag and a sticky summary-overflow flag. It also produces the four-bit record field (negative, positive, zero, summary) that a branch unit reads. The adder itself is outside: the unit receives both operands and the finished result, an add/subtract select, and three independent enables. One enable updates carry, one updates overflow and one updates the record field.

Software can read the status register at any time and can overwrite it. A write is the only way to clear the sticky summary bit. The record field reports the summary bit as it stands after the same operation's own overflow update. A brand-new overflow therefore appears in the record field of the instruction that caused it.

Top module: `int_flag_unit`

## Requirements
- R1: After reset the status register reads 0 and the record field reads 4'b0000.
- R2: With the carry enable high and add selected (op_sub=0), bit 29 of the status register is set on the next cycle exactly when unsigned res < unsigned opa, and is cleared otherwise.
- R3: With the carry enable high and subtract selected (op_sub=1), bit 29 is set on the next cycle exactly when unsigned opa >= unsigned opb, and is cleared otherwise.
- R4: Overflow is detected in two cases. For add, opa and opb have equal sign bits and res has a different sign bit from opa. For subtract, opa and opb have different sign bits and res has a different sign bit from opa. With the overflow enable high and overflow detected, bit 30 (OV) and bit 31 (SO) are both set on the next cycle.
- R5: With the overflow enable high and no overflow detected, bit 30 is cleared and bit 31 keeps its value.
- R6: With the record enable high, the record field on the next cycle holds a code taken from res read as a signed value: 4'b1000 for negative, 4'b0100 for positive and 4'b0010 for zero. Bit 0 of the field is bit 31 of the status register after this cycle's own update.
- R7: A status register write (xr_we=1) loads xr_wdata whole and overrides every carry and overflow update in the same cycle. A record update in that same cycle takes its bit 0 from the written bit 31.
- R8: A flag whose enable is low keeps its value. The record field keeps its value while the record enable is low.
- R9: Status bits 28:0 hold the last written value and are never changed by flag updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| res | input | 32 | Result from the external adder |
| ca_en | input | 1 | Update carry |
| ov_en | input | 1 | Update overflow and summary |
| rec_en | input | 1 | Update record field |
| xr_we | input | 1 | Write status register |
| xr_wdata | input | 32 | Status register write data |
| xr_rdata | output | 32 | Status register contents |
| cr0 | output | 4 | Record field (bit 3 negative .. bit 0 summary) |

## Verification
The bench builds the unit with its default 32-bit data path and 32-bit status register. This puts the sign boundary at bit 31, the unsigned wrap at 2^32, and the flag positions 31:29 of the requirements directly in reach of both directed and random stimulus. The directed cases cover the largest-positive plus one, the all-ones wrap, equal operands on subtract, and a zero result. Random operands reach both signs and both carry outcomes many times over. Rare random writes exercise the sticky summary clear and the write-over-update priority.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} ifu_op_e;

  localparam logic [3:0] REC_NEG  = 4'b1000;
  localparam logic [3:0] REC_POS  = 4'b0100;
  localparam logic [3:0] REC_ZERO = 4'b0010;
endpackage

// File: rtl/ifu_arith_flags.sv
module ifu_arith_flags #(
  parameter int DATA_W = 32
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] res_i,
  output logic              carry_o,
  output logic              ovf_o
);
  import ifu_pkg::*;
  localparam int MSB = DATA_W - 1;

  logic sgn_ab_diff;
  logic sgn_ar_diff;

  assign sgn_ab_diff = a_i[MSB] ^ b_i[MSB];
  assign sgn_ar_diff = a_i[MSB] ^ res_i[MSB];

  always_comb begin
    if (ifu_op_e'(sub_i) == OP_SUB) begin
      carry_o = !(a_i < b_i);
      ovf_o   = sgn_ab_diff & sgn_ar_diff;
    end else begin
      carry_o = (res_i < a_i);
      ovf_o   = !sgn_ab_diff & sgn_ar_diff;
    end
  end
endmodule

// File: rtl/ifu_rec_gen.sv
module ifu_rec_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              so_i,
  output logic [3:0]        code_o
);
  import ifu_pkg::*;

  always_comb begin
    if (res_i[DATA_W-1])
      code_o = REC_NEG;
    else if (res_i != '0)
      code_o = REC_POS;
    else
      code_o = REC_ZERO;
    code_o[0] = code_o[0] | so_i;
  end
endmodule

// File: rtl/ifu_xr_reg.sv
module ifu_xr_reg #(
  parameter int XR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [XR_W-1:0] wdata_i,
  input  logic            ca_en_i,
  input  logic            carry_i,
  input  logic            ov_en_i,
  input  logic            ovf_i,
  output logic [XR_W-1:0] q_o,
  output logic            so_next_o
);
  localparam int SO_BIT = XR_W - 1;
  localparam int OV_BIT = XR_W - 2;
  localparam int CA_BIT = XR_W - 3;

  logic [XR_W-1:0] xr_q;
  logic [XR_W-1:0] xr_d;
  logic            xr_en;

  always_comb begin
    xr_d  = xr_q;
    xr_en = we_i | ca_en_i | ov_en_i;
    if (we_i) begin
      xr_d = wdata_i;
    end else begin
      if (ca_en_i)
        xr_d[CA_BIT] = carry_i;
      if (ov_en_i) begin
        xr_d[OV_BIT] = ovf_i;
        if (ovf_i)
          xr_d[SO_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      xr_q <= '0;
    else if (xr_en)
      xr_q <= xr_d;
  end

  assign q_o       = xr_q;
  assign so_next_o = xr_d[SO_BIT];
endmodule

// File: rtl/int_flag_unit.sv
module int_flag_unit #(
  parameter int DATA_W = 32,
  parameter int XR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_sub,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              ca_en,
  input  logic              ov_en,
  input  logic              rec_en,
  input  logic              xr_we,
  input  logic [XR_W-1:0]   xr_wdata,
  output logic [XR_W-1:0]   xr_rdata,
  output logic [3:0]        cr0
);
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic       carry_w;
  logic       ovf_w;
  logic       so_next_w;
  logic [3:0] rec_code_w;

  ifu_arith_flags #(.DATA_W(DATA_W)) u_arith (
    .sub_i   (op_sub),
    .a_i     (opa),
    .b_i     (opb),
    .res_i   (res),
    .carry_o (carry_w),
    .ovf_o   (ovf_w)
  );

  ifu_xr_reg #(.XR_W(XR_W)) u_xr (
    .clk       (clk),
    .rst_n     (rst_ok),
    .we_i      (xr_we),
    .wdata_i   (xr_wdata),
    .ca_en_i   (ca_en),
    .carry_i   (carry_w),
    .ov_en_i   (ov_en),
    .ovf_i     (ovf_w),
    .q_o       (xr_rdata),
    .so_next_o (so_next_w)
  );

  ifu_rec_gen #(.DATA_W(DATA_W)) u_rec (
    .res_i  (res),
    .so_i   (so_next_w),
    .code_o (rec_code_w)
  );

  logic [3:0] cr0_q;
  logic [3:0] cr0_d;

  always_comb begin
    cr0_d = rec_en ? rec_code_w : cr0_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)
      cr0_q <= 4'b0000;
    else if (rec_en)
      cr0_q <= cr0_d;
  end

  assign cr0 = cr0_q;
endmodule

// File: rtl/int_flag_unit_chk.sv
module int_flag_unit_chk #(
  parameter int DATA_W = 32,
  parameter int XR_W   = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              op_sub,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] res,
  input logic              ca_en,
  input logic              ov_en,
  input logic              rec_en,
  input logic              xr_we,
  input logic [XR_W-1:0]   xr_wdata,
  input logic [XR_W-1:0]   xr_rdata,
  input logic [3:0]        cr0
);
  localparam int M = DATA_W - 1;
  logic ovf_seen;
  assign ovf_seen = op_sub ? ((opa[M] != opb[M]) && (res[M] != opa[M]))
                           : ((opa[M] == opb[M]) && (res[M] != opa[M]));

  // R4: detected overflow raises both OV and SO
  p_ovf_sets_both_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (ov_en && !xr_we && ovf_seen) |=> (xr_rdata[XR_W-1] && xr_rdata[XR_W-2]));

  // R5: summary bit only drops through a write
  p_so_sticky_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!xr_we && xr_rdata[XR_W-1]) |=> xr_rdata[XR_W-1]);

  // R7: a write lands whole
  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    xr_we |=> (xr_rdata == $past(xr_wdata)));

  // R6: exactly one of negative/positive/zero after a record update
  p_rec_onehot_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    rec_en |=> ($countones(cr0[3:1]) == 1));

  // R6: record summary follows status summary
  p_rec_so_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    rec_en |=> (cr0[0] == xr_rdata[XR_W-1]));

  // R8: carry untouched without enable or write
  p_ca_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ca_en && !xr_we) |=> $stable(xr_rdata[XR_W-3]));

  // R8: record field untouched without enable
  p_rec_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !rec_en |=> $stable(cr0));

  // R9: low bits untouched without a write
  p_low_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !xr_we |=> $stable(xr_rdata[XR_W-4:0]));
endmodule

bind int_flag_unit int_flag_unit_chk #(.DATA_W(DATA_W), .XR_W(XR_W)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .op_sub   (op_sub),
  .opa      (opa),
  .opb      (opb),
  .res      (res),
  .ca_en    (ca_en),
  .ov_en    (ov_en),
  .rec_en   (rec_en),
  .xr_we    (xr_we),
  .xr_wdata (xr_wdata),
  .xr_rdata (xr_rdata),
  .cr0      (cr0)
);

// File: tb/int_flag_unit_tb_top.sv
`timescale 1ns/1ps
module int_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] opa = '0, opb = '0, res = '0;
  logic        ca_en = 1'b0, ov_en = 1'b0, rec_en = 1'b0, xr_we = 1'b0;
  logic [31:0] xr_wdata = '0;
  logic [31:0] xr_rdata;
  logic [3:0]  cr0;

  int total = 0;
  int bad   = 0;
  logic [31:0] m_xr = '0;
  logic [3:0]  m_cr = '0;

  always #2.5 clk = ~clk;

  int_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .opa(opa), .opb(opb), .res(res),
    .ca_en(ca_en), .ov_en(ov_en), .rec_en(rec_en), .xr_we(xr_we),
    .xr_wdata(xr_wdata), .xr_rdata(xr_rdata), .cr0(cr0)
  );

  function automatic logic f_carry(logic s, logic [31:0] a, logic [31:0] b, logic [31:0] r);
    return s ? (a >= b) : (r < a);
  endfunction

  function automatic logic f_ovf(logic s, logic [31:0] a, logic [31:0] b, logic [31:0] r);
    if (s) return (a[31] != b[31]) && (r[31] != a[31]);
    return (a[31] == b[31]) && (r[31] != a[31]);
  endfunction

  function automatic logic [3:0] f_rec(logic [31:0] r, logic so);
    logic [3:0] c;
    if ($signed(r) < 0) c = 4'b1000;
    else if (r != 0)    c = 4'b0100;
    else                c = 4'b0010;
    c[0] = so;
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic s, logic [31:0] a, logic [31:0] b, logic [31:0] r,
                      logic ce, logic oe, logic re, logic we, logic [31:0] wd,
                      string tag);
    op_sub = s; opa = a; opb = b; res = r;
    ca_en = ce; ov_en = oe; rec_en = re; xr_we = we; xr_wdata = wd;
    @(posedge clk);
    if (we) m_xr = wd;
    else begin
      if (ce) m_xr[29] = f_carry(s, a, b, r);
      if (oe) begin
        m_xr[30] = f_ovf(s, a, b, r);
        if (m_xr[30]) m_xr[31] = 1'b1;
      end
    end
    if (re) m_cr = f_rec(r, m_xr[31]);
    @(negedge clk);
    ca_en = 0; ov_en = 0; rec_en = 0; xr_we = 0;
    check({tag, " status"}, xr_rdata, m_xr);
    check({tag, " record"}, {28'd0, cr0}, {28'd0, m_cr});
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset status", xr_rdata, 32'h0);
    check("R1 reset record", {28'd0, cr0}, 32'h0);

    step(0, 32'hFFFF_FFFF, 32'h1, 32'h0, 1, 0, 0, 0, 0, "R2 add wrap carry");
    step(0, 32'h10, 32'h1, 32'h11, 1, 0, 0, 0, 0, "R2 add no carry");
    step(1, 32'h5, 32'h5, 32'h0, 1, 0, 1, 0, 0, "R3 sub equal carry, R6 zero");
    step(1, 32'h4, 32'h5, 32'hFFFF_FFFF, 1, 0, 1, 0, 0, "R3 sub borrow, R6 neg");
    step(0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, 1, 1, 0, 0, "R4 add ovf, R6 new SO");
    step(0, 32'h1, 32'h1, 32'h2, 0, 1, 1, 0, 0, "R5 clear OV keep SO, R6 pos");
    step(1, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 0, 1, 0, 0, 0, "R4 sub ovf");
    step(0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1, 1, 1, 1, 32'h1234_5678, "R7 write wins");
    step(0, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 0, "R8 idle hold");
    step(0, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 0, 0, 0, "R8 disabled carry");
    step(0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1, 1, 0, 0, 0, "R9 low bits kept");
    step(0, 32'h3, 32'h4, 32'h7, 0, 0, 1, 1, 32'h8000_0000, "R7 record uses written SO");

    for (int i = 0; i < 3000; i++) begin
      logic s;
      logic [31:0] a, b, r;
      s = 1'($urandom);
      a = $urandom; b = $urandom;
      if ($urandom % 8 == 0) a = {1'($urandom), 31'(($urandom % 2) ? 32'h7FFF_FFFF : 32'h0)};
      r = s ? a - b : a + b;
      if ($urandom % 10 == 0) r = $urandom;
      if ($urandom % 12 == 0) r = 0;
      step(s, a, b, r, 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 25 == 0), $urandom, "R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule